// File: doc/BRIEF.md
# Programmable Raster Timing Generator for Parallel RGB Panels

This block drives the timing side of a parallel RGB TFT panel. From a fast core clock it forms a pixel-clock enable by a programmable division. On every pixel step it walks a horizontal and a vertical position counter through sync pulse, back porch, active area and front porch. For each pixel it presents horizontal sync, vertical sync, data-enable and the active-area coordinates. The pixel fetch and blending logic of a display pipeline uses the enable and the coordinates to place its data.

Software writes porch and pulse lengths, the active size, the clock ratio and the sync polarity into shadow registers. The running raster takes them over as one set, at a frame boundary, and only after an update has been requested, so a frame never mixes two timings. A vertical-blank event latches a status bit that can raise an interrupt.

Top module: `lcd_raster_timer`

## Requirements
- R1: Each line runs, in pixels, hsync pulse (HTIM bits 19:10), back porch (HTIM bits 29:20), active width (16 × SIZE bits 7:0), front porch (HTIM bits 9:0). `hsync` is asserted only during the pulse. While `de` is high, `pix_x` counts 0 upward from the first active pixel.
- R2: Each frame runs, in lines, vsync pulse (VTIM bits 19:10), back porch (VTIM bits 29:20), active height (SIZE bits 27:16), front porch (VTIM bits 9:0). `vsync` is asserted for the whole of the pulse lines. While `de` is high, `pix_y` counts 0 upward from the first active line.
- R3: `de` is high only when both positions are in their active regions. `pix_x` and `pix_y` are 0 whenever `de` is low.
- R4: `pix_ce` pulses once every N core cycles, where N is DIV bits 7:0. A ratio of 0 or 1 makes it pulse every cycle. Outputs change only together with a `pix_ce` pulse.
- R5: POL bit 0 inverts `hsync` and POL bit 1 inverts `vsync`, so a set bit makes that sync active low.
- R6: The raster runs only when CTRL bit 0 (enable) is 1 and CTRL bits 2:1 (mode) equal 01. Otherwise `pix_ce`, `de`, `pix_x` and `pix_y` stay 0, and each sync sits at its inactive level. Starting the raster begins at pixel (0,0).
- R7: Writes to HTIM (addr 1), VTIM (addr 2), SIZE (addr 3), DIV (addr 4) and POL (addr 5) change only the shadow set, which reads back as written. The running raster output is unaffected by them until an update is applied.
- R8: Writing 1 to CTRL bit 3 requests an update. Bit 3 reads 1 while the request is pending. While running, the shadow set is applied from the first pixel of the next frame. While stopped, it is applied at once. The bit then clears by itself.
- R9: Leaving the last active line sets ISTAT (addr 6) bit 0 at the first pixel of the next line. Writing 1 to that bit clears it.
- R10: `irq` is high exactly when ISTAT bit 0 is 1 and IMASK (addr 7) bit 0 is 0. IMASK bit 0 resets to 1 (masked).
- R11: After reset all outputs are 0, CTRL reads 0, the timing registers read 0 and IMASK reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, one cycle after the address |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data-enable, active area |
| pix_x | output | 12 | Active-area column |
| pix_y | output | 12 | Active-area row |
| pix_ce | output | 1 | Pixel enable, high while a new pixel is presented |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
Two directed timings are used, one of them with unit clock ratio and normal polarity. The other has a ratio of three, both syncs inverted, a different width and porches. Together they separate errors in line ordering from errors in polarity and in divider pacing, and they make a shadow write that leaks early show up as a mismatch. The switch between the two is requested mid-frame, so an update applied too early breaks the tail of the running frame and one applied too late breaks the next frame. Seeded random timings then cover zero-length sync pulses, a zero front porch (where the blank event lands on the frame wrap) and ratios of 0 and 1, all against a pixel-by-pixel model.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int PORCH_W  = 10;
  localparam int WUNIT_W  = 8;
  localparam int HEIGHT_W = 12;
  localparam int DIV_W    = 8;
  localparam int XPOS_W   = WUNIT_W + 4;
  localparam int HCNT_W   = XPOS_W + 2;
  localparam int VCNT_W   = HEIGHT_W + 2;

  // field positions inside the timing and size words
  localparam int FP_LSB   = 0;
  localparam int PW_LSB   = FP_LSB + PORCH_W;
  localparam int BP_LSB   = PW_LSB + PORCH_W;
  localparam int HGT_LSB  = DATA_W / 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_HTIM  = 3'd1,
    RA_VTIM  = 3'd2,
    RA_SIZE  = 3'd3,
    RA_DIV   = 3'd4,
    RA_POL   = 3'd5,
    RA_ISTAT = 3'd6,
    RA_IMASK = 3'd7
  } reg_addr_e;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_NORMAL = 2'd1;

  typedef struct packed {
    logic [PORCH_W-1:0]  hpw;
    logic [PORCH_W-1:0]  hbp;
    logic [PORCH_W-1:0]  hfp;
    logic [PORCH_W-1:0]  vpw;
    logic [PORCH_W-1:0]  vbp;
    logic [PORCH_W-1:0]  vfp;
    logic [WUNIT_W-1:0]  wunits;
    logic [HEIGHT_W-1:0] height;
    logic [DIV_W-1:0]    ratio;
    logic                hinv;
    logic                vinv;
  } tcfg_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              load_ack,
  input  logic              vb_evt,
  output tcfg_t             shadow,
  output logic              upd_pend,
  output logic              run,
  output logic              irq
);
  logic       en_q;
  logic [1:0] mode_q;
  logic       stat_q;
  logic       mask_q;
  logic       set_req;
  logic       clr_stat;
  logic [DATA_W-1:0] rd_mux;

  assign set_req  = wr_en && (wr_addr == RA_CTRL) && wr_data[3];
  assign clr_stat = wr_en && (wr_addr == RA_ISTAT) && wr_data[0];
  assign run      = en_q && (mode_q == MODE_NORMAL);
  assign irq      = stat_q && !mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= '0;
      en_q     <= 1'b0;
      mode_q   <= MODE_OFF;
      upd_pend <= 1'b0;
      stat_q   <= 1'b0;
      mask_q   <= 1'b1;
    end else begin
      if (set_req)       upd_pend <= 1'b1;
      else if (load_ack) upd_pend <= 1'b0;

      if (vb_evt)        stat_q <= 1'b1;
      else if (clr_stat) stat_q <= 1'b0;

      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            en_q   <= wr_data[0];
            mode_q <= wr_data[2:1];
          end
          RA_HTIM: begin
            shadow.hfp <= wr_data[FP_LSB +: PORCH_W];
            shadow.hpw <= wr_data[PW_LSB +: PORCH_W];
            shadow.hbp <= wr_data[BP_LSB +: PORCH_W];
          end
          RA_VTIM: begin
            shadow.vfp <= wr_data[FP_LSB +: PORCH_W];
            shadow.vpw <= wr_data[PW_LSB +: PORCH_W];
            shadow.vbp <= wr_data[BP_LSB +: PORCH_W];
          end
          RA_SIZE: begin
            shadow.wunits <= wr_data[0 +: WUNIT_W];
            shadow.height <= wr_data[HGT_LSB +: HEIGHT_W];
          end
          RA_DIV:   shadow.ratio <= wr_data[0 +: DIV_W];
          RA_POL: begin
            shadow.hinv <= wr_data[0];
            shadow.vinv <= wr_data[1];
          end
          RA_IMASK: mask_q <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_mux[0]   = en_q;
        rd_mux[2:1] = mode_q;
        rd_mux[3]   = upd_pend;
      end
      RA_HTIM: begin
        rd_mux[FP_LSB +: PORCH_W] = shadow.hfp;
        rd_mux[PW_LSB +: PORCH_W] = shadow.hpw;
        rd_mux[BP_LSB +: PORCH_W] = shadow.hbp;
      end
      RA_VTIM: begin
        rd_mux[FP_LSB +: PORCH_W] = shadow.vfp;
        rd_mux[PW_LSB +: PORCH_W] = shadow.vpw;
        rd_mux[BP_LSB +: PORCH_W] = shadow.vbp;
      end
      RA_SIZE: begin
        rd_mux[0 +: WUNIT_W]        = shadow.wunits;
        rd_mux[HGT_LSB +: HEIGHT_W] = shadow.height;
      end
      RA_DIV:   rd_mux[0 +: DIV_W] = shadow.ratio;
      RA_POL:   rd_mux[1:0] = {shadow.vinv, shadow.hinv};
      RA_ISTAT: rd_mux[0] = stat_q;
      RA_IMASK: rd_mux[0] = mask_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R8: an accepted load retires the request unless a new one arrives
  p_req_retire_r8: assert property (@(posedge clk) disable iff (rst)
    (load_ack && !set_req) |=> !upd_pend);

  // R9: status only rises after a blank event from the raster
  p_stat_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(vb_evt));

  // R9: status stays set until a clearing write
  p_stat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_stat) |=> stat_q);
endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] dc;

  assign tick = (ratio <= DIV_W'(1)) || (dc >= ratio - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) dc <= '0;
    else if (tick)   dc <= '0;
    else             dc <= dc + DIV_W'(1);
  end

  // R4: with a ratio above one, two ticks never follow back to back
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && ratio > DIV_W'(1)) |=> (!tick || !run || ratio != $past(ratio)));
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
  import lcdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                tick,
  input  tcfg_t               shadow,
  input  logic                upd_pend,
  output logic                load,
  output tcfg_t               act,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic [XPOS_W-1:0]   x_o,
  output logic [HEIGHT_W-1:0] y_o,
  output logic                pix_ce_o,
  output logic                vb_evt
);
  logic              started;
  logic [HCNT_W-1:0] hc, hn, htot, ha0, ha1;
  logic [VCNT_W-1:0] vc, vn, vtot, va0, va1, vact_end;
  logic              line_end, last_pix, frame_start;
  logic              h_in, v_in, hs_n, vs_n;
  tcfg_t             use_c;

  always_comb begin
    htot = HCNT_W'(act.hpw) + HCNT_W'(act.hbp) + HCNT_W'({act.wunits, 4'b0000})
         + HCNT_W'(act.hfp);
    vtot = VCNT_W'(act.vpw) + VCNT_W'(act.vbp) + VCNT_W'(act.height)
         + VCNT_W'(act.vfp);
    vact_end    = VCNT_W'(act.vpw) + VCNT_W'(act.vbp) + VCNT_W'(act.height);
    line_end    = (hc == htot - HCNT_W'(1));
    last_pix    = line_end && (vc == vtot - VCNT_W'(1));
    frame_start = run && tick && (!started || last_pix);
    load        = upd_pend && (!run || frame_start);
    use_c       = load ? shadow : act;
    vb_evt      = run && tick && started && line_end
                  && (vc + VCNT_W'(1) == vact_end);

    if (frame_start) begin
      hn = '0;
      vn = '0;
    end else if (line_end) begin
      hn = '0;
      vn = vc + VCNT_W'(1);
    end else begin
      hn = hc + HCNT_W'(1);
      vn = vc;
    end

    ha0  = HCNT_W'(use_c.hpw) + HCNT_W'(use_c.hbp);
    ha1  = ha0 + HCNT_W'({use_c.wunits, 4'b0000});
    va0  = VCNT_W'(use_c.vpw) + VCNT_W'(use_c.vbp);
    va1  = va0 + VCNT_W'(use_c.height);
    h_in = (hn >= ha0) && (hn < ha1);
    v_in = (vn >= va0) && (vn < va1);
    hs_n = (hn < HCNT_W'(use_c.hpw)) ^ use_c.hinv;
    vs_n = (vn < VCNT_W'(use_c.vpw)) ^ use_c.vinv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= '0;
      started  <= 1'b0;
      hc       <= '0;
      vc       <= '0;
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      de_o     <= 1'b0;
      x_o      <= '0;
      y_o      <= '0;
      pix_ce_o <= 1'b0;
    end else begin
      if (load) act <= shadow;
      pix_ce_o <= run && tick;
      if (!run) begin
        started <= 1'b0;
        hc      <= '0;
        vc      <= '0;
        hsync_o <= use_c.hinv;
        vsync_o <= use_c.vinv;
        de_o    <= 1'b0;
        x_o     <= '0;
        y_o     <= '0;
      end else if (tick) begin
        started <= 1'b1;
        hc      <= hn;
        vc      <= vn;
        hsync_o <= hs_n;
        vsync_o <= vs_n;
        de_o    <= h_in && v_in;
        x_o     <= (h_in && v_in) ? XPOS_W'(hn - ha0) : '0;
        y_o     <= (h_in && v_in) ? HEIGHT_W'(vn - va0) : '0;
      end
    end
  end

  // R6: a stopped raster presents no pixel and no data
  p_idle_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!de_o && !pix_ce_o));

  // R1: active column stays inside the programmed width
  p_x_bound_r1: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (x_o < {act.wunits, 4'b0000}));

  // R2: active row stays inside the programmed height
  p_y_bound_r2: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (y_o < act.height));

  // R3: the sync pulses never overlap the active area
  p_de_no_sync_r3: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hsync_o == act.hinv && vsync_o == act.vinv));

  // R9: the blank event is a single-cycle pulse
  p_evt_single_r9: assert property (@(posedge clk) disable iff (rst)
    vb_evt |=> !vb_evt);
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic [XPOS_W-1:0]   pix_x,
  output logic [HEIGHT_W-1:0] pix_y,
  output logic                pix_ce,
  output logic                irq
);
  tcfg_t shadow;
  tcfg_t act;
  logic  upd_pend, run, load, vb_evt, tick;

  lcdt_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .load_ack (load),
    .vb_evt   (vb_evt),
    .shadow   (shadow),
    .upd_pend (upd_pend),
    .run      (run),
    .irq      (irq)
  );

  lcdt_pixdiv u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .ratio (act.ratio),
    .tick  (tick)
  );

  lcdt_raster u_raster (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .shadow   (shadow),
    .upd_pend (upd_pend),
    .load     (load),
    .act      (act),
    .hsync_o  (hsync),
    .vsync_o  (vsync),
    .de_o     (de),
    .x_o      (pix_x),
    .y_o      (pix_y),
    .pix_ce_o (pix_ce),
    .vb_evt   (vb_evt)
  );
endmodule

// File: tb/test_lcd_raster_timer.sv
`timescale 1ns/1ps
module test_lcd_raster_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        hsync, vsync, de, pix_ce, irq;
  logic [11:0] pix_x, pix_y;

  lcd_raster_timer i_lcd_raster_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .pix_ce(pix_ce), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // model: active set (m_*) and pending set (n_*)
  int m_hpw, m_hbp, m_hfp, m_w16, m_vpw, m_vbp, m_vfp, m_ht, m_div, m_hi, m_vi;
  int n_hpw, n_hbp, n_hfp, n_w16, n_vpw, n_vbp, n_vfp, n_ht, n_div, n_hi, n_vi;
  bit bench_pend = 0;
  bit mon_on = 0, m_started = 0, irq_chk = 0, irq_prev = 0;
  int mh = 0, mv = 0, m_frames = 0, last_ce = 0;
  int e_h = 0, e_v = 0, e_de = 0, e_div = 0, e_irq = 0, n_rise = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected below 180000", cyc);
      summary();
    end
  end

  function automatic int htot_m(); return m_hpw + m_hbp + 16*m_w16 + m_hfp; endfunction
  function automatic int vtot_m(); return m_vpw + m_vbp + m_ht + m_vfp; endfunction

  task automatic take_pending();
    m_hpw = n_hpw; m_hbp = n_hbp; m_hfp = n_hfp; m_w16 = n_w16;
    m_vpw = n_vpw; m_vbp = n_vbp; m_vfp = n_vfp; m_ht = n_ht;
    m_div = n_div; m_hi = n_hi; m_vi = n_vi;
  endtask

  // pixel monitor
  always @(negedge clk) begin
    if (mon_on && pix_ce) begin
      bit first, swapped, hin, vin, edeb;
      int hs, vs, ex, ey, gap, vbv;
      first = 0; swapped = 0;
      if (!m_started) begin
        mh = 0; mv = 0; m_started = 1; first = 1;
      end else if (mh == htot_m() - 1) begin
        mh = 0;
        if (mv == vtot_m() - 1) begin
          mv = 0; m_frames++;
          if (bench_pend) begin take_pending(); bench_pend = 0; swapped = 1; end
        end else mv++;
      end else mh++;
      gap = (m_div <= 1) ? 1 : m_div;
      if (!first && !swapped && (cyc - last_ce != gap)) e_div++;
      last_ce = cyc;
      hs = m_hpw + m_hbp; vs = m_vpw + m_vbp;
      hin = (mh >= hs) && (mh < hs + 16*m_w16);
      vin = (mv >= vs) && (mv < vs + m_ht);
      edeb = hin && vin;
      ex = edeb ? mh - hs : 0;
      ey = edeb ? mv - vs : 0;
      if (int'(hsync) != (int'(mh < m_hpw) ^ m_hi) || int'(pix_x) != ex) e_h++;
      if (int'(vsync) != (int'(mv < m_vpw) ^ m_vi) || int'(pix_y) != ey) e_v++;
      if (de != edeb) e_de++;
      vbv = (vs + m_ht) % vtot_m();
      if (irq_chk && irq && !irq_prev) begin
        n_rise++;
        if (!(mh == 0 && mv == vbv && !first)) e_irq++;
      end
    end
    irq_prev = irq;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  function automatic int tim(input int bp, input int pw, input int fp);
    return (bp << 20) | (pw << 10) | fp;
  endfunction

  task automatic set_cfg(input int hpw, hbp, hfp, w16, vpw, vbp, vfp, ht, dv, hi, vi);
    n_hpw = hpw; n_hbp = hbp; n_hfp = hfp; n_w16 = w16;
    n_vpw = vpw; n_vbp = vbp; n_vfp = vfp; n_ht = ht;
    n_div = dv; n_hi = hi; n_vi = vi;
    wr(1, tim(hbp, hpw, hfp));
    wr(2, tim(vbp, vpw, vfp));
    wr(3, (ht << 16) | w16);
    wr(4, dv);
    wr(5, (vi << 1) | hi);
  endtask

  task automatic clr_err();
    e_h = 0; e_v = 0; e_de = 0; e_div = 0; e_irq = 0; n_rise = 0;
  endtask

  task automatic start_run();
    m_started = 0; mon_on = 1;
    wr(0, 32'h3);
  endtask

  task automatic stop_run();
    mon_on = 0;
    wr(0, 0);
  endtask

  task automatic run_frames(input int n);
    int f0;
    f0 = m_frames;
    while (m_frames < f0 + n) @(posedge clk);
  endtask

  task automatic wait_safe();
    @(posedge clk);
    while (!(mon_on && m_started && mv == m_vpw + m_vbp && mh == 0)) @(posedge clk);
  endtask

  initial begin
    int v, bad;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!hsync && !vsync && !de && !pix_ce && !irq, "R11 outputs after reset",
        int'({hsync, vsync, de, pix_ce, irq}), 0);
    chk(pix_x == 0 && pix_y == 0, "R11 coordinates after reset", int'(pix_x) + int'(pix_y), 0);
    rd(0, v); chk(v == 0, "R11 CTRL after reset", v, 0);
    rd(1, v); chk(v == 0, "R11 HTIM after reset", v, 0);
    rd(7, v); chk(v == 1, "R11 R10 IMASK after reset", v, 1);

    // configuration A while stopped
    set_cfg(2, 3, 4, 1, 1, 2, 2, 3, 1, 0, 0);
    rd(1, v); chk(v == tim(3, 2, 4), "R7 HTIM shadow readback", v, tim(3, 2, 4));
    rd(3, v); chk(v == ((3 << 16) | 1), "R7 SIZE shadow readback", v, (3 << 16) | 1);
    wr(0, 32'h8);
    take_pending();
    repeat (2) @(negedge clk);
    rd(0, v); chk(((v >> 3) & 1) == 0, "R8 request clears while stopped", (v >> 3) & 1, 0);
    chk(!de && !pix_ce && !hsync && !vsync, "R6 idle before enable",
        int'({de, pix_ce, hsync, vsync}), 0);

    clr_err();
    start_run();
    run_frames(2);
    chk(e_h == 0, "R1 line order, hsync and pix_x", e_h, 0);
    chk(e_v == 0, "R2 frame order, vsync and pix_y", e_v, 0);
    chk(e_de == 0, "R3 data-enable region", e_de, 0);
    chk(e_div == 0, "R4 pixel enable every cycle at ratio 1", e_div, 0);

    // R9 / R10: status with mask set, clear, then unmask
    wait_safe();
    rd(6, v); chk(v == 1, "R9 vblank status set", v, 1);
    chk(!irq, "R10 irq held off by mask", int'(irq), 0);
    wr(6, 1);
    rd(6, v); chk(v == 0, "R9 write-one clears status", v, 0);
    wr(7, 0);
    clr_err(); irq_chk = 1;
    run_frames(1);
    chk(irq && n_rise == 1 && e_irq == 0, "R10 irq rises at blank start when unmasked",
        n_rise * 10 + e_irq, 10);
    irq_chk = 0;
    wr(6, 1); wr(7, 1);
    @(negedge clk);
    chk(!irq, "R10 irq drops after clear and mask", int'(irq), 0);

    // R7: shadow writes without request do not disturb the frame
    wait_safe();
    clr_err();
    set_cfg(1, 2, 3, 2, 2, 1, 1, 4, 3, 1, 1);
    run_frames(2);
    chk(e_h + e_v + e_de + e_div == 0, "R7 running timing unchanged by shadow writes",
        e_h + e_v + e_de + e_div, 0);

    // R8: request mid-frame, applied at next frame start
    wait_safe();
    clr_err();
    wr(0, 32'hB);
    bench_pend = 1;
    rd(0, v); chk(((v >> 3) & 1) == 1, "R8 request pending reads one", (v >> 3) & 1, 1);
    run_frames(3);
    chk(e_h + e_v + e_de == 0, "R8 new timing from next frame start", e_h + e_v + e_de, 0);
    rd(0, v); chk(v == 3, "R8 request self-clears after apply", v, 3);
    chk(e_h + e_v == 0, "R5 inverted sync polarity", e_h + e_v, 0);
    chk(e_div == 0, "R4 pixel enable every third cycle", e_div, 0);

    // R6: stopping and reserved/off modes
    stop_run();
    repeat (2) @(negedge clk);
    chk(!de && !pix_ce && pix_x == 0 && pix_y == 0, "R6 no data when stopped",
        int'({de, pix_ce}), 0);
    chk(hsync && vsync, "R6 R5 syncs idle at inactive level", int'({hsync, vsync}), 3);
    wr(0, 32'h1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pix_ce || de) bad++;
    end
    chk(bad == 0, "R6 enable with mode off stays idle", bad, 0);
    wr(0, 32'h5);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pix_ce || de) bad++;
    end
    chk(bad == 0, "R6 reserved mode stays idle", bad, 0);
    wr(0, 0);

    // seeded random timings
    for (int it = 0; it < 5; it++) begin
      int a1, a2, a3, a4, a5, a6, a7, a8, a9, a10, a11;
      a1 = $urandom_range(0, 3); a2 = $urandom_range(0, 3); a3 = $urandom_range(0, 3);
      a4 = $urandom_range(1, 2); a5 = $urandom_range(0, 2); a6 = $urandom_range(0, 2);
      a7 = (it == 0) ? 0 : $urandom_range(0, 2); a8 = $urandom_range(1, 3);
      a9 = (it == 1) ? 0 : $urandom_range(0, 4); a10 = $urandom_range(0, 1);
      a11 = $urandom_range(0, 1);
      set_cfg(a1, a2, a3, a4, a5, a6, a7, a8, a9, a10, a11);
      wr(0, 32'h8);
      take_pending();
      repeat (2) @(negedge clk);
      clr_err();
      start_run();
      run_frames(2);
      chk(e_h == 0, "R1 random timing horizontal", e_h, 0);
      chk(e_v == 0, "R2 random timing vertical", e_v, 0);
      chk(e_de == 0, "R3 random timing data-enable", e_de, 0);
      chk(e_div == 0, "R4 random divider pacing", e_div, 0);
      stop_run();
      repeat (2) @(negedge clk);
    end
    summary();
  end
endmodule